// File: doc/BRIEF.md
# Odd-Even Merging Network

This block takes two lists of unsigned words, each already in ascending order, and returns all of their entries as one ascending list. Both lists arrive in parallel as packed vectors. The merged list leaves the same way, one word per slot. The lengths of the two lists are separate parameters and need not be equal.

The network is built recursively. The entries at even 0-based positions of both lists go to one smaller merge, and the entries at odd positions go to another. A final row of compare-exchange cells then combines the two results. A merge of one word with one word is a single compare-exchange cell. A merge where one side is empty passes the other side straight through.

A parameter can add a register after every comparator rank. In that case the block accepts a new pair of lists on every cycle, and the result appears a fixed number of cycles later. Without the parameter the network is purely combinational.

Top module: `om_merge`

## Requirements
- R1: When both input lists are ascending, `merged` is ascending: the word in slot k+1 is never smaller than the word in slot k.
- R2: `merged` holds exactly the words of the two inputs, each kept with its multiplicity, so the sum of the output words equals the sum of the input words.
- R3: Repeated values within one list and equal values shared between the two lists each come out the correct number of times, in adjacent slots.
- R4: Any list lengths S ≥ 1 and T ≥ 1 are supported, equal or not, including a list of length one.
- R5: With PIPE=1 the result for the inputs present before clock edge n appears after edge n+L, where L is the number of comparator ranks: L=1 for a 1-by-1 merge, and otherwise L is one more than the larger rank count of the two half merges. This gives L=3 for (3,2), for (4,4) and for (4,3). With PIPE=0 the output follows the inputs in the same cycle.
- R6: With PIPE=1, while `rst` is high at a rising edge, every pipeline register is cleared, so `merged` reads all zeros whatever the inputs are.
- R7: Word k of every list occupies bits [k*W +: W]. Slot 0 holds the smallest word, and slot S+T-1 holds the largest.
- R8: Slot 0 of `merged` equals the smaller of the two lowest input words. The top slot equals the larger of the two highest input words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst | input | 1 | Synchronous active-high reset of the pipeline registers |
| a_list | input | W*S | First ascending list, word k at bits [k*W +: W] |
| b_list | input | W*T | Second ascending list, same packing |
| merged | output | W*(S+T) | Merged ascending list, same packing |

## Verification
The bench covers every pair of sorted lists in three small configurations:
- 3-bit words with lengths 3 and 2,
- 2-bit words with lengths 4 and 4,
- 2-bit words with lengths 1 and 4, built combinationally.

Narrow words force many ties, both within one list and across the two lists. A network that dropped or duplicated a tied word would fail the reference merge, and a faulty pairing in the final row would leave out-of-order neighbours. Because the pipelined configurations receive a new pair of lists every cycle, a wrong delay-line length on one half merge would mix words from different input cycles. An error of one in the overall latency would compare against the wrong entry. A check during reset with non-zero inputs catches pipeline registers that are not cleared.

// File: rtl/om_pkg.sv
package om_pkg;

    // Number of comparator ranks that an s-by-t merge needs.
    function automatic int merge_depth(input int s, input int t);
        int d_odd;
        int d_even;
        if (s == 0 || t == 0) return 0;
        if (s == 1 && t == 1) return 1;
        d_odd  = merge_depth((s + 1) / 2, (t + 1) / 2);
        d_even = merge_depth(s / 2, t / 2);
        return ((d_odd > d_even) ? d_odd : d_even) + 1;
    endfunction

    // Width helper: a zero-length list still gets one slot of wiring.
    function automatic int at_least_one(input int n);
        return (n > 0) ? n : 1;
    endfunction

endpackage

// File: rtl/om_cmp_cell.sv
module om_cmp_cell #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic         swap;
    logic [W-1:0] lo_c;
    logic [W-1:0] hi_c;

    always_comb begin
        swap = (x > y);
        lo_c = swap ? y : x;
        hi_c = swap ? x : y;
    end

    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo <= '0;
                    hi <= '0;
                end else begin
                    lo <= lo_c;
                    hi <= hi_c;
                end
            end
        end else begin : g_comb
            assign lo = lo_c;
            assign hi = hi_c;
        end
    endgenerate
endmodule

// File: rtl/om_delay.sv
module om_delay #(
    parameter int WD     = 8,
    parameter int STAGES = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WD-1:0] din,
    output logic [WD-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WD-1:0] stage_q [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
                end
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/om_merge_node.sv
module om_merge_node
    import om_pkg::*;
#(
    parameter int W    = 8,
    parameter int S    = 2,
    parameter int T    = 2,
    parameter bit PIPE = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [W*at_least_one(S)-1:0]      a_in,
    input  logic [W*at_least_one(T)-1:0]      b_in,
    output logic [W*at_least_one(S+T)-1:0]    m_out
);
    generate
        if (S == 0) begin : g_pass_b
            assign m_out = b_in;
        end else if (T == 0) begin : g_pass_a
            assign m_out = a_in;
        end else if (S == 1 && T == 1) begin : g_leaf
            om_cmp_cell #(.W(W), .REG(PIPE)) u_cell (
                .clk(clk), .rst(rst),
                .x(a_in[0 +: W]), .y(b_in[0 +: W]),
                .lo(m_out[0 +: W]), .hi(m_out[W +: W])
            );
        end else begin : g_split
            localparam int OS   = (S + 1) / 2;
            localparam int OT   = (T + 1) / 2;
            localparam int ES   = S / 2;
            localparam int ET   = T / 2;
            localparam int ON   = OS + OT;
            localparam int EN   = ES + ET;
            localparam int N    = S + T;
            localparam int D    = merge_depth(S, T);
            localparam int DO   = merge_depth(OS, OT);
            localparam int DE   = merge_depth(ES, ET);
            localparam int PADO = PIPE ? (D - 1 - DO) : 0;
            localparam int PADE = PIPE ? (D - 1 - DE) : 0;
            localparam int NPR  = (EN < ON - 1) ? EN : (ON - 1);

            logic [W*OS-1:0]               odd_a;
            logic [W*OT-1:0]               odd_b;
            logic [W*at_least_one(ES)-1:0] even_a;
            logic [W*at_least_one(ET)-1:0] even_b;
            logic [W*ON-1:0]               odd_m;
            logic [W*EN-1:0]               even_m;
            logic [W*ON-1:0]               odd_d;
            logic [W*EN-1:0]               even_d;

            // 1-based odd positions are 0-based even slots.
            for (genvar k = 0; k < OS; k++) begin : g_oa
                assign odd_a[k*W +: W] = a_in[(2*k)*W +: W];
            end
            for (genvar k = 0; k < OT; k++) begin : g_ob
                assign odd_b[k*W +: W] = b_in[(2*k)*W +: W];
            end
            if (ES == 0) begin : g_ea_none
                assign even_a = '0;
            end else begin : g_ea
                for (genvar k = 0; k < ES; k++) begin : g_e
                    assign even_a[k*W +: W] = a_in[(2*k+1)*W +: W];
                end
            end
            if (ET == 0) begin : g_eb_none
                assign even_b = '0;
            end else begin : g_eb
                for (genvar k = 0; k < ET; k++) begin : g_e
                    assign even_b[k*W +: W] = b_in[(2*k+1)*W +: W];
                end
            end

            om_merge_node #(.W(W), .S(OS), .T(OT), .PIPE(PIPE)) u_odd (
                .clk(clk), .rst(rst), .a_in(odd_a), .b_in(odd_b), .m_out(odd_m)
            );
            om_merge_node #(.W(W), .S(ES), .T(ET), .PIPE(PIPE)) u_even (
                .clk(clk), .rst(rst), .a_in(even_a), .b_in(even_b), .m_out(even_m)
            );

            // Balance the two halves so the final row sees one input cycle.
            om_delay #(.WD(W*ON), .STAGES(PADO)) u_pad_odd (
                .clk(clk), .rst(rst), .din(odd_m), .dout(odd_d)
            );
            om_delay #(.WD(W*EN), .STAGES(PADE)) u_pad_even (
                .clk(clk), .rst(rst), .din(even_m), .dout(even_d)
            );

            // Lowest odd-merge word goes straight to slot 0.
            om_delay #(.WD(W), .STAGES(PIPE ? 1 : 0)) u_low (
                .clk(clk), .rst(rst), .din(odd_d[0 +: W]), .dout(m_out[0 +: W])
            );

            // Final row: even word i-1 meets odd word i.
            for (genvar i = 1; i <= NPR; i++) begin : g_row
                om_cmp_cell #(.W(W), .REG(PIPE)) u_cell (
                    .clk(clk), .rst(rst),
                    .x(even_d[(i-1)*W +: W]), .y(odd_d[i*W +: W]),
                    .lo(m_out[(2*i-1)*W +: W]), .hi(m_out[(2*i)*W +: W])
                );
            end

            // An unpartnered word becomes the largest output.
            if (ON - 1 > EN) begin : g_left_odd
                om_delay #(.WD(W), .STAGES(PIPE ? 1 : 0)) u_top (
                    .clk(clk), .rst(rst),
                    .din(odd_d[(ON-1)*W +: W]), .dout(m_out[(N-1)*W +: W])
                );
            end else if (EN > ON - 1) begin : g_left_even
                om_delay #(.WD(W), .STAGES(PIPE ? 1 : 0)) u_top (
                    .clk(clk), .rst(rst),
                    .din(even_d[(EN-1)*W +: W]), .dout(m_out[(N-1)*W +: W])
                );
            end
        end
    endgenerate
endmodule

// File: rtl/om_merge.sv
module om_merge
    import om_pkg::*;
#(
    parameter int W    = 8,
    parameter int S    = 4,
    parameter int T    = 3,
    parameter bit PIPE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W*S-1:0]     a_list,
    input  logic [W*T-1:0]     b_list,
    output logic [W*(S+T)-1:0] merged
);
    localparam int N    = S + T;
    localparam int LAT  = PIPE ? merge_depth(S, T) : 0;
    localparam int SUMW = W + $clog2(N) + 1;

    om_merge_node #(.W(W), .S(S), .T(T), .PIPE(PIPE)) u_root (
        .clk(clk), .rst(rst), .a_in(a_list), .b_in(b_list), .m_out(merged)
    );

    // Shadow references, delayed by the network latency, for the checks.
    logic [W-1:0]    in_min;
    logic [W-1:0]    in_max;
    logic [SUMW-1:0] in_sum;
    logic [SUMW-1:0] out_sum;
    logic [W-1:0]    ref_min;
    logic [W-1:0]    ref_max;
    logic [SUMW-1:0] ref_sum;
    logic            out_sorted;

    always_comb begin
        in_min = (a_list[0 +: W] < b_list[0 +: W]) ? a_list[0 +: W] : b_list[0 +: W];
        in_max = (a_list[(S-1)*W +: W] > b_list[(T-1)*W +: W]) ?
                 a_list[(S-1)*W +: W] : b_list[(T-1)*W +: W];
        in_sum = '0;
        for (int k = 0; k < S; k++) in_sum += SUMW'(a_list[k*W +: W]);
        for (int k = 0; k < T; k++) in_sum += SUMW'(b_list[k*W +: W]);
        out_sum = '0;
        out_sorted = 1'b1;
        for (int k = 0; k < N; k++) out_sum += SUMW'(merged[k*W +: W]);
        for (int k = 0; k < N - 1; k++)
            if (merged[k*W +: W] > merged[(k+1)*W +: W]) out_sorted = 1'b0;
    end

    om_delay #(.WD(W), .STAGES(LAT)) u_ref_min (
        .clk(clk), .rst(rst), .din(in_min), .dout(ref_min)
    );
    om_delay #(.WD(W), .STAGES(LAT)) u_ref_max (
        .clk(clk), .rst(rst), .din(in_max), .dout(ref_max)
    );
    om_delay #(.WD(SUMW), .STAGES(LAT)) u_ref_sum (
        .clk(clk), .rst(rst), .din(in_sum), .dout(ref_sum)
    );

    p_sorted_r1: assert property (@(posedge clk) disable iff (rst) out_sorted)
        else $error("merged output not ascending");
    p_sum_kept_r2: assert property (@(posedge clk) disable iff (rst) out_sum == ref_sum)
        else $error("merged output lost or gained a word");
    p_low_slot_r8: assert property (@(posedge clk) disable iff (rst)
                                    merged[0 +: W] == ref_min)
        else $error("slot 0 is not the smallest input");
    p_top_slot_r8: assert property (@(posedge clk) disable iff (rst)
                                    merged[(N-1)*W +: W] == ref_max)
        else $error("top slot is not the largest input");
endmodule

// File: tb/om_merge_tb.sv
module om_merge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_A = 3;   // (3,2)
    localparam int LAT_S = 3;   // (4,4)

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [8:0]  a_a = '0;  logic [5:0] b_a = '0;  logic [14:0] m_a;
    logic [7:0]  a_s = '0;  logic [7:0] b_s = '0;  logic [15:0] m_s;
    logic [1:0]  a_c = '0;  logic [7:0] b_c = '0;  logic [9:0]  m_c;

    om_merge #(.W(3), .S(3), .T(2), .PIPE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .a_list(a_a), .b_list(b_a), .merged(m_a));
    om_merge #(.W(2), .S(4), .T(4), .PIPE(1'b1)) u_dut_sq (
        .clk(clk), .rst(rst), .a_list(a_s), .b_list(b_s), .merged(m_s));
    om_merge #(.W(2), .S(1), .T(4), .PIPE(1'b0)) u_dut_comb (
        .clk(clk), .rst(rst), .a_list(a_c), .b_list(b_c), .merged(m_c));

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [23:0] ring [8];
    int n_applied;

    function automatic int field(input logic [23:0] v, input int k, input int w);
        return int'((v >> (k*w)) & ((24'd1 << w) - 24'd1));
    endfunction

    function automatic bit ascending(input logic [23:0] v, input int n, input int w);
        for (int k = 0; k < n - 1; k++)
            if (field(v, k, w) > field(v, k + 1, w)) return 1'b0;
        return 1'b1;
    endfunction

    // Reference: gather all words and insertion-sort them.
    function automatic logic [23:0] ref_merge(input logic [23:0] av, input logic [23:0] bv,
                                             input int s, input int t, input int w);
        int vals [16];
        int n;
        int tmp;
        logic [23:0] r;
        n = 0;
        for (int k = 0; k < s; k++) begin vals[n] = field(av, k, w); n++; end
        for (int k = 0; k < t; k++) begin vals[n] = field(bv, k, w); n++; end
        for (int i = 1; i < n; i++)
            for (int j = i; j > 0 && vals[j-1] > vals[j]; j--) begin
                tmp = vals[j]; vals[j] = vals[j-1]; vals[j-1] = tmp;
            end
        r = '0;
        for (int k = 0; k < n; k++) r |= 24'(vals[k]) << (k*w);
        return r;
    endfunction

    function automatic logic [23:0] out_of(input int sel);
        case (sel)
            0:       return {9'b0, m_a};
            1:       return {8'b0, m_s};
            default: return {14'b0, m_c};
        endcase
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge: check the word due now, then drive the next pair.
    task automatic step_pipe(input int sel, input logic [23:0] av, input logic [23:0] bv,
                             input int s, input int t, input int w, input int lat);
        if (n_applied >= lat)
            check("R1 R2 R3 R4 R5", out_of(sel), ring[(n_applied - lat) % 8]);
        if (sel == 0) begin a_a = av[8:0]; b_a = bv[5:0]; end
        else          begin a_s = av[7:0]; b_s = bv[7:0]; end
        ring[n_applied % 8] = ref_merge(av, bv, s, t, w);
        n_applied++;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] last_a;
        logic [23:0] last_b;

        // R6: reset clears the pipelines even with non-zero inputs.
        a_a = {3'd7, 3'd5, 3'd2}; b_a = {3'd6, 3'd1};
        a_s = 8'hE4;              b_s = 8'hFF;
        repeat (4) @(negedge clk);
        check("R6", {9'b0, m_a}, 24'd0);
        check("R6", {8'b0, m_s}, 24'd0);
        rst = 1'b0;

        // Sweep 1: every sorted (3,2) pair with 3-bit words.
        n_applied = 0;
        last_a = '0; last_b = '0;
        for (int ca = 0; ca < 512; ca++) begin
            if (!ascending(24'(ca), 3, 3)) continue;
            for (int cb = 0; cb < 64; cb++) begin
                if (!ascending(24'(cb), 2, 3)) continue;
                step_pipe(0, 24'(ca), 24'(cb), 3, 2, 3, LAT_A);
                last_a = 24'(ca); last_b = 24'(cb);
            end
        end
        repeat (LAT_A) step_pipe(0, last_a, last_b, 3, 2, 3, LAT_A);

        // Sweep 2: every sorted (4,4) pair with 2-bit words.
        n_applied = 0;
        for (int ca = 0; ca < 256; ca++) begin
            if (!ascending(24'(ca), 4, 2)) continue;
            for (int cb = 0; cb < 256; cb++) begin
                if (!ascending(24'(cb), 4, 2)) continue;
                step_pipe(1, 24'(ca), 24'(cb), 4, 4, 2, LAT_S);
                last_a = 24'(ca); last_b = 24'(cb);
            end
        end
        repeat (LAT_S) step_pipe(1, last_a, last_b, 4, 4, 2, LAT_S);

        // Sweep 3: combinational (1,4), output valid in the same cycle (R5, R4).
        for (int ca = 0; ca < 4; ca++) begin
            for (int cb = 0; cb < 256; cb++) begin
                if (!ascending(24'(cb), 4, 2)) continue;
                a_c = 2'(ca); b_c = 8'(cb);
                #1;
                check("R4 R5 R3", {14'b0, m_c}, ref_merge(24'(ca), 24'(cb), 1, 4, 2));
                @(negedge clk);
            end
        end

        // R7: slot packing, a=[3], b=[0,1,2,2] -> 0,1,2,2,3 = 10'h3A4.
        a_c = 2'd3; b_c = {2'd2, 2'd2, 2'd1, 2'd0};
        #1;
        check("R7", {14'b0, m_c}, 24'h3A4);
        // R8: lowest from list a, highest from list b.
        a_c = 2'd0; b_c = {2'd3, 2'd3, 2'd3, 2'd3};
        #1;
        check("R8", {14'b0, m_c}, 24'h3FC);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule